// File: doc/BRIEF.md
# Set-Associative Translation Lookup Unit

This block looks up virtual-to-physical page translations for a paged memory management unit. Each lookup carries a 32-bit virtual address, an access type and the current process identifier. The virtual page number (the address shifted right by 12, so 4 KB pages) picks one set, and every way of that set is compared in parallel. One cycle later the unit returns a hit flag, the physical page address, the read, write and execute permissions, a pass-through cacheable flag, and a flag that says whether the requested access type is permitted.

Entries are loaded through a separate write port. A write carries a tag word, a data word and a way number. The set is taken from the tag's own page number. Page-table walks, fault generation and cache control belong to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `rsp_valid_o` and every response output are zero, and all stored entries are invalid, so any lookup misses until something is written.
- R2: Every cycle in which `req_valid_i` is high at a rising edge produces exactly one response cycle with `rsp_valid_o` high, one cycle later. Back-to-back requests give back-to-back responses, and a cycle without a request gives no response.
- R3: The set searched is the low IDX_W bits of VPN = vaddr[31:12], with IDX_W = log2(NUM_ENTRIES/NUM_WAYS). An entry stored under another set is never considered, and an entry in the right set with a different full VPN misses.
- R4: A way hits when all three hold: the valid bit (tag bit 10) is set, the tag VPN (bits 31:12) equals the lookup VPN, and either the global bit (tag bit 11) is set or the tag process ID (tag bits PID_W-1:0) equals `req_pid_i`.
- R5: When more than one way hits, the response takes the lowest-numbered hitting way.
- R6: On a hit, `rsp_paddr_o` is the frame number (data bits 19:0) shifted left by 12. `rsp_ex_o` is data bit 20, `rsp_wr_o` is data bit 21, `rsp_rd_o` is data bit 22 and `rsp_cache_o` is data bit 23.
- R7: On a miss, or in a cycle with no response, `rsp_hit_o`, `rsp_paddr_o`, all permission flags, `rsp_cache_o` and `rsp_allow_o` are zero.
- R8: `rsp_allow_o` is high only on a hit, and only if the entry grants the requested access. Access code 0 (read) needs R, code 1 (write) needs W, code 2 (fetch) needs X, and code 3 is never allowed.
- R9: With `wr_en_i` high at a rising edge, the tag and data are stored in way `wr_way_i` at the set given by the low bits of the tag's VPN, replacing that entry. A lookup in the same cycle sees the old contents, and the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_pid_i | input | PID_W | Current process identifier |
| wr_en_i | input | 1 | Entry write strobe |
| wr_way_i | input | WAY_W | Way to write |
| wr_tag_i | input | 32 | Tag word: VPN 31:12, global 11, valid 10, process ID low bits |
| wr_data_i | input | 24 | Data word: cacheable 23, R 22, W 21, X 20, frame number 19:0 |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_hit_o | output | 1 | Translation found |
| rsp_paddr_o | output | 32 | Physical page address |
| rsp_rd_o | output | 1 | Read permitted by entry |
| rsp_wr_o | output | 1 | Write permitted by entry |
| rsp_ex_o | output | 1 | Execute permitted by entry |
| rsp_cache_o | output | 1 | Cacheable flag passed through |
| rsp_allow_o | output | 1 | Requested access type is permitted |

## Verification
Every lookup result is due exactly one rising edge after the request edge, and an entry write takes effect at its own edge, so the first lookup that can see it is the one presented in the next cycle. The driver presents inputs at falling edges and pushes the expected response, tagged with the cycle in which it must appear, into a queue. The monitor pops one item at each falling edge where the response strobe is high and compares all fields and the arrival cycle. In cycles without a strobe it checks that every output is zero.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;

  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned VPN_W      = 32 - PAGE_SHIFT;
  localparam int unsigned PFN_W      = 20;
  localparam int unsigned TAG_LOW_W  = 10;
  localparam int unsigned DATA_W     = PFN_W + 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  // bit 11 global, bit 10 valid, low bits hold the process id
  typedef struct packed {
    logic [VPN_W-1:0]     vpn;
    logic                 glob;
    logic                 vld;
    logic [TAG_LOW_W-1:0] low;
  } tlb_tag_t;

  typedef struct packed {
    logic             cache;
    logic             rd;
    logic             wr;
    logic             ex;
    logic [PFN_W-1:0] pfn;
  } tlb_data_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned SETS     = 4,
  localparam int unsigned IDX_W   = $clog2(SETS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [WAY_W-1:0]           wr_way_i,
  input  tlb_tag_t                   wr_tag_i,
  input  tlb_data_t                  wr_data_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output tlb_tag_t  [NUM_WAYS-1:0]   rd_tag_o,
  output tlb_data_t [NUM_WAYS-1:0]   rd_data_o
);

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wr_tag_i.vpn[IDX_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_tag_t  tag_q  [SETS];
    tlb_data_t data_q [SETS];
    logic      way_we;

    assign way_we = wr_en_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[s]  <= '0;
          data_q[s] <= '0;
        end
      end else if (way_we) begin
        tag_q[wr_idx]  <= wr_tag_i;
        data_q[wr_idx] <= wr_data_i;
      end
    end

    assign rd_tag_o[w]  = tag_q[rd_idx_i];
    assign rd_data_o[w] = data_q[rd_idx_i];
  end

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned PID_W = 8
) (
  input  tlb_tag_t          tag_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic              match_o
);

  logic vpn_eq;
  logic pid_ok;

  assign vpn_eq  = (tag_i.vpn == vpn_i);
  assign pid_ok  = tag_i.glob || (tag_i.low[PID_W-1:0] == pid_i);
  assign match_o = tag_i.vld && vpn_eq && pid_ok;

  if (PID_W < TAG_LOW_W) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^tag_i.low[TAG_LOW_W-1:PID_W];
  end

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic      [NUM_WAYS-1:0] match_i,
  input  tlb_data_t [NUM_WAYS-1:0] data_i,
  output logic                     hit_o,
  output tlb_data_t                data_o
);

  // scan downward so the lowest matching way is the last to assign
  always_comb begin
    data_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) data_o = data_i[w];
    end
  end

  assign hit_o = |match_i;

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned NUM_WAYS    = 4,
  parameter int unsigned PID_W       = 8,
  localparam int unsigned SETS       = NUM_ENTRIES / NUM_WAYS,
  localparam int unsigned IDX_W      = $clog2(SETS),
  localparam int unsigned WAY_W      = $clog2(NUM_WAYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [31:0]        req_vaddr_i,
  input  logic [1:0]         req_acc_i,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic               wr_en_i,
  input  logic [WAY_W-1:0]   wr_way_i,
  input  logic [31:0]        wr_tag_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [31:0]        rsp_paddr_o,
  output logic               rsp_rd_o,
  output logic               rsp_wr_o,
  output logic               rsp_ex_o,
  output logic               rsp_cache_o,
  output logic               rsp_allow_o
);

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic unused_offset;

  assign vpn = req_vaddr_i[31:PAGE_SHIFT];
  assign idx = vpn[IDX_W-1:0];
  assign unused_offset = ^req_vaddr_i[PAGE_SHIFT-1:0];

  tlb_tag_t  [NUM_WAYS-1:0] set_tag;
  tlb_data_t [NUM_WAYS-1:0] set_data;
  logic      [NUM_WAYS-1:0] way_hit;

  tlb_entry_store #(
    .NUM_WAYS (NUM_WAYS),
    .SETS     (SETS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_way_i  (wr_way_i),
    .wr_tag_i  (tlb_tag_t'(wr_tag_i)),
    .wr_data_i (tlb_data_t'(wr_data_i)),
    .rd_idx_i  (idx),
    .rd_tag_o  (set_tag),
    .rd_data_o (set_data)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    tlb_way_match #(
      .PID_W (PID_W)
    ) u_match (
      .tag_i   (set_tag[w]),
      .vpn_i   (vpn),
      .pid_i   (req_pid_i),
      .match_o (way_hit[w])
    );
  end

  logic      any_hit;
  tlb_data_t sel;

  tlb_hit_select #(
    .NUM_WAYS (NUM_WAYS)
  ) u_sel (
    .match_i (way_hit),
    .data_i  (set_data),
    .hit_o   (any_hit),
    .data_o  (sel)
  );

  logic grant;
  always_comb begin
    unique case (acc_e'(req_acc_i))
      ACC_LOAD:  grant = sel.rd;
      ACC_STORE: grant = sel.wr;
      ACC_FETCH: grant = sel.ex;
      default:   grant = 1'b0;
    endcase
  end

  logic      vld_q;
  logic      hit_q;
  logic      allow_q;
  tlb_data_t data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      allow_q <= 1'b0;
      data_q  <= '0;
    end else begin
      vld_q   <= req_valid_i;
      hit_q   <= req_valid_i && any_hit;
      allow_q <= req_valid_i && any_hit && grant;
      data_q  <= (req_valid_i && any_hit) ? sel : '0;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_hit_o   = hit_q;
  assign rsp_allow_o = allow_q;
  assign rsp_paddr_o = {data_q.pfn, {PAGE_SHIFT{1'b0}}};
  assign rsp_rd_o    = data_q.rd;
  assign rsp_wr_o    = data_q.wr;
  assign rsp_ex_o    = data_q.ex;
  assign rsp_cache_o = data_q.cache;

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [1:0]  req_acc_i,
  input logic        rsp_valid_o,
  input logic        rsp_hit_o,
  input logic [31:0] rsp_paddr_o,
  input logic        rsp_rd_o,
  input logic        rsp_wr_o,
  input logic        rsp_ex_o,
  input logic        rsp_cache_o,
  input logic        rsp_allow_o
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R2
  no_rsp_without_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_hit_o && rsp_paddr_o == '0 && !rsp_allow_o);

  // R7
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> rsp_paddr_o == '0 && !rsp_rd_o && !rsp_wr_o && !rsp_ex_o
                   && !rsp_cache_o && !rsp_allow_o);

  // R8
  allow_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_allow_o |-> rsp_hit_o);

  // R8
  allow_matches_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |->
      rsp_allow_o == (($past(req_acc_i) == 2'd0 && rsp_rd_o) ||
                      ($past(req_acc_i) == 2'd1 && rsp_wr_o) ||
                      ($past(req_acc_i) == 2'd2 && rsp_ex_o)));

endmodule

bind tlb_lookup tlb_lookup_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_acc_i   (req_acc_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_rd_o    (rsp_rd_o),
  .rsp_wr_o    (rsp_wr_o),
  .rsp_ex_o    (rsp_ex_o),
  .rsp_cache_o (rsp_cache_o),
  .rsp_allow_o (rsp_allow_o)
);

// File: tb/tlb_lookup_tb.sv
`timescale 1ns/1ps
module tlb_lookup_tb;

  localparam int NW    = 4;
  localparam int NE    = 16;
  localparam int SETS  = NE / NW;
  localparam int PID_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0] req_acc_i = '0;
  logic [PID_W-1:0] req_pid_i = '0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_way_i = '0;
  logic [31:0] wr_tag_i = '0;
  logic [23:0] wr_data_i = '0;
  logic rsp_valid_o, rsp_hit_o, rsp_rd_o, rsp_wr_o, rsp_ex_o, rsp_cache_o, rsp_allow_o;
  logic [31:0] rsp_paddr_o;

  always #2.5 clk = ~clk;

  tlb_lookup #(.NUM_ENTRIES(NE), .NUM_WAYS(NW), .PID_W(PID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i),
    .req_acc_i(req_acc_i), .req_pid_i(req_pid_i),
    .wr_en_i(wr_en_i), .wr_way_i(wr_way_i), .wr_tag_i(wr_tag_i), .wr_data_i(wr_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_paddr_o(rsp_paddr_o),
    .rsp_rd_o(rsp_rd_o), .rsp_wr_o(rsp_wr_o), .rsp_ex_o(rsp_ex_o),
    .rsp_cache_o(rsp_cache_o), .rsp_allow_o(rsp_allow_o)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_tag [NW][SETS];
  logic [23:0] m_dat [NW][SETS];

  // {hit, allow, cache, rd, wr, ex, paddr}
  logic [37:0] exp_q [$];
  int          due_q [$];
  string       req_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_tag(logic [19:0] vpn, logic g, logic v, logic [7:0] pid);
    return {vpn, g, v, 2'b00, pid};
  endfunction

  function automatic logic [23:0] mk_dat(logic c, logic r, logic w, logic x, logic [19:0] pfn);
    return {c, r, w, x, pfn};
  endfunction

  function automatic logic [37:0] predict(logic [31:0] va, logic [1:0] acc, logic [7:0] pid);
    logic [19:0] vpn = va[31:12];
    int s = int'(vpn[1:0]);
    for (int w = 0; w < NW; w++) begin
      logic [31:0] t = m_tag[w][s];
      logic [23:0] d = m_dat[w][s];
      if (t[10] && t[31:12] == vpn && (t[11] || t[7:0] == pid)) begin
        logic al;
        al = (acc == 2'd0 && d[22]) || (acc == 2'd1 && d[21]) || (acc == 2'd2 && d[20]);
        return {1'b1, al, d[23], d[22], d[21], d[20], d[19:0], 12'h000};
      end
    end
    return '0;
  endfunction

  task automatic check(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic push_req(logic [31:0] va, logic [1:0] acc, logic [7:0] pid, string r);
    exp_q.push_back(predict(va, acc, pid));
    due_q.push_back(cyc + 1);
    req_q.push_back(r);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    req_acc_i   = acc;
    req_pid_i   = pid;
  endtask

  task automatic lookup(logic [31:0] va, logic [1:0] acc, logic [7:0] pid, string r);
    @(negedge clk);
    wr_en_i = 1'b0;
    push_req(va, acc, pid, r);
  endtask

  task automatic put_entry(logic [1:0] way, logic [31:0] tag, logic [23:0] dat);
    wr_en_i   = 1'b1;
    wr_way_i  = way;
    wr_tag_i  = tag;
    wr_data_i = dat;
    m_tag[way][tag[13:12]] = tag;
    m_dat[way][tag[13:12]] = dat;
  endtask

  task automatic write(logic [1:0] way, logic [31:0] tag, logic [23:0] dat);
    @(negedge clk);
    req_valid_i = 1'b0;
    put_entry(way, tag, dat);
  endtask

  // lookup predicted from old contents, then the write lands at the same edge
  task automatic write_and_lookup(logic [1:0] way, logic [31:0] tag, logic [23:0] dat,
                                  logic [31:0] va, logic [7:0] pid, string r);
    @(negedge clk);
    push_req(va, 2'd0, pid, r);
    put_entry(way, tag, dat);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid_i = 1'b0;
      wr_en_i     = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [37:0] act;
      act = {rsp_hit_o, rsp_allow_o, rsp_cache_o, rsp_rd_o, rsp_wr_o, rsp_ex_o, rsp_paddr_o};
      if (rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected response", 64'(1), 64'(0));
        end else begin
          logic [37:0] e;
          int due;
          string r;
          e = exp_q.pop_front();
          due = due_q.pop_front();
          r = req_q.pop_front();
          check({r, " R2 latency"}, 64'(cyc), 64'(due));
          check(r, 64'(act), 64'(e));
        end
      end else begin
        check("R7 idle outputs zero", 64'(act), 64'(0));
      end
    end
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < SETS; s++) begin
        m_tag[w][s] = '0;
        m_dat[w][s] = '0;
      end
    repeat (3) @(negedge clk);
    // R1 outputs held at zero in reset
    check("R1 reset outputs", 64'({rsp_valid_o, rsp_hit_o, rsp_allow_o, rsp_cache_o,
                                   rsp_rd_o, rsp_wr_o, rsp_ex_o, rsp_paddr_o}), 64'(0));
    rst_ni = 1'b1;
    lookup(32'h0000_0000, 2'd0, 8'd0, "R1 empty after reset");

    write(2'd0, mk_tag(20'h00012, 1'b0, 1'b1, 8'd5), mk_dat(1'b0, 1'b1, 1'b0, 1'b1, 20'hABCDE));
    lookup(32'h0001_2ABC, 2'd0, 8'd5, "R4 R6 basic hit");
    lookup(32'h0001_2ABC, 2'd0, 8'd6, "R4 pid mismatch");
    lookup(32'h0001_6ABC, 2'd0, 8'd5, "R3 same set other vpn");
    lookup(32'h0001_3ABC, 2'd0, 8'd5, "R3 other set");
    lookup(32'h0001_2000, 2'd1, 8'd5, "R8 write denied");
    lookup(32'h0001_2000, 2'd2, 8'd5, "R8 fetch allowed");
    lookup(32'h0001_2000, 2'd3, 8'd5, "R8 code 3 denied");

    write(2'd2, mk_tag(20'h00103, 1'b1, 1'b1, 8'd9), mk_dat(1'b1, 1'b1, 1'b1, 1'b0, 20'h12345));
    lookup(32'h0010_3FFF, 2'd1, 8'd1, "R4 R6 global hit cache");
    lookup(32'h0010_3000, 2'd2, 8'd9, "R8 global fetch denied");

    write(2'd1, mk_tag(20'h00200, 1'b0, 1'b0, 8'd3), mk_dat(1'b0, 1'b1, 1'b1, 1'b1, 20'h00777));
    lookup(32'h0020_0000, 2'd0, 8'd3, "R4 invalid entry misses");

    write(2'd3, mk_tag(20'h00301, 1'b0, 1'b1, 8'd7), mk_dat(1'b0, 1'b1, 1'b0, 1'b0, 20'h33333));
    write(2'd1, mk_tag(20'h00301, 1'b0, 1'b1, 8'd7), mk_dat(1'b0, 1'b0, 1'b1, 1'b0, 20'h11111));
    write(2'd0, mk_tag(20'h00305, 1'b0, 1'b1, 8'd7), mk_dat(1'b0, 1'b1, 1'b1, 1'b1, 20'h00001));
    lookup(32'h0030_1010, 2'd1, 8'd7, "R5 lowest way wins");
    write(2'd1, mk_tag(20'h00301, 1'b0, 1'b0, 8'd7), mk_dat(1'b0, 1'b0, 1'b1, 1'b0, 20'h11111));
    lookup(32'h0030_1010, 2'd0, 8'd7, "R9 R5 overwrite falls to way3");

    write_and_lookup(2'd0, mk_tag(20'h00012, 1'b0, 1'b1, 8'd5),
                     mk_dat(1'b0, 1'b1, 1'b1, 1'b0, 20'h55555),
                     32'h0001_2000, 8'd5, "R9 same-cycle sees old");
    lookup(32'h0001_2000, 2'd1, 8'd5, "R9 next cycle sees new");

    idle(3);
    lookup(32'h0010_3000, 2'd0, 8'd2, "R2 back-to-back a");
    lookup(32'h0030_1000, 2'd0, 8'd7, "R2 back-to-back b");
    lookup(32'h0099_9000, 2'd0, 8'd7, "R2 R7 back-to-back miss");
    idle(4);
    check("R2 all responses seen", 64'(exp_q.size()), 64'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule